// File: doc/BRIEF.md
# Speculative Rice Delimiter Marker

This block accepts one N-bit chunk of a Rice-coded bit stream per cycle and labels every bit of it under each possible carry-in condition at once. A Rice code word is a run of 1 bits closed by a single 0 (the unary quotient), then exactly K binary remainder bits. The stream is read from bit 0 upward. A chunk boundary can fall anywhere inside a code word, so the meaning of bit 0 depends on earlier chunks. The block does not wait for that information. It evaluates all K+1 possibilities in parallel: either a unary run continues into the chunk, or j remainder bits (1 ≤ j ≤ K) carry over.

Each possibility is a lane. For each lane the block returns a remainder-flag vector and a delimiter-flag vector, and it returns the chunk data once. The delimiter is the last bit of each code word, which is its last remainder bit, or the closing 0 when K is 0. Each lane is a chain of marking cells, one cell for each code word that can begin in the chunk. A later stage, which is not part of this block, uses the previous chunk's outcome to pick the correct lane. Outputs pass through a configurable number of register stages and come with a valid bit.

Top module: `rice_spec_marker`

## Requirements
- R1: The block has K+1 lanes. Lane j occupies bits [j*N +: N] of `out_rem` and `out_delim`, and bit i of a lane refers to chunk bit i.
- R2: In lane 0, every bit from bit 0 up to and including the first 0 bit is unary, so neither of its flags is set.
- R3: In lane j (j ≥ 1), bits 0 to j-1 are flagged as remainder, bit j-1 is flagged as delimiter, and parsing resumes at bit j as the start of a new unary run.
- R4: After every 0 that closes a unary run, the next K bits are flagged as remainder and the K-th of them is flagged as delimiter. The next code word starts at the bit after it.
- R5: When a remainder runs past bit N-1, its in-chunk bits are flagged as remainder and no delimiter is set for that code word.
- R6: A unary run that reaches bit N-1 without a closing 0 leaves all of its bits unflagged.
- R7: With K > 0, every delimiter bit is also a remainder bit, and a bit of a unary run is never flagged.
- R8: `out_valid` and `out_data` repeat `in_valid` and `in_data` exactly LAT cycles later, and the flags belong to that same chunk.
- R9: After reset, `out_valid` stays 0 until a valid chunk has passed through the pipeline.
- R10: With K = 0 there is a single lane, every 0 bit is a delimiter, and the remainder vector is all zeros.
- R11: A new chunk can be accepted every cycle, each chunk is marked independently of its neighbours, and `out_valid` is never 1 without a matching input chunk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input chunk is present |
| in_data | input | N | Coded chunk; bit 0 comes first in the stream |
| out_valid | output | 1 | Marked chunk is present |
| out_data | output | N | Chunk data, delayed by LAT cycles |
| out_rem | output | (K+1)*N | Remainder flags, one N-bit field per lane |
| out_delim | output | (K+1)*N | Delimiter flags, one N-bit field per lane |

## Verification
Within a single lane and a single chunk, complete code words can be delimited while the last code word is cut off at bit N-1. Its remainder bits are then flagged with no delimiter, or its unary run is left unflagged. The lanes that carry remainder bits in (j ≥ 1) add a third case to the same chunk. All-zero chunks and chunks made mostly of ones provoke these overlaps, and so do random back-to-back chunks. A bit-serial reference model walks each lane bit by bit and judges the result, and directed checks compare known corner chunks against hand-computed masks.

// File: rtl/rice_mark_pkg.sv
// Shared helpers for the speculative Rice marker.
// Assumes K < N so that every carried-in remainder ends inside the chunk.
package rice_mark_pkg;

    // Upper bound on the number of code words that can begin in n bits
    // when each code word is at least k+1 bits long.
    function automatic int unsigned cells_for(input int unsigned n, input int unsigned k);
        return (n + k) / (k + 1);
    endfunction

endpackage

// File: rtl/rice_mark_cell.sv
// One marking cell. It finds the first 0 bit that no earlier cell has
// covered (the close of the next unary run), flags the K bits after it as
// remainder and the K-th as delimiter (the 0 itself when K is 0), and
// extends the covered mask past that code word. When no uncovered 0 is
// left, the cell marks the whole chunk as covered and adds no flags.
// Assumes that cov_i is contiguous from bit 0.
module rice_mark_cell #(
    parameter int N = 16,
    parameter int K = 2
) (
    input  logic [N-1:0] data_i,
    input  logic [N-1:0] cov_i,
    input  logic [N-1:0] rem_i,
    input  logic [N-1:0] dlm_i,
    output logic [N-1:0] cov_o,
    output logic [N-1:0] rem_o,
    output logic [N-1:0] dlm_o
);

    logic [N-1:0] cand;
    logic [N-1:0] first0;
    logic [N-1:0] rem_new;
    logic [N-1:0] dlm_new;

    // Locate the closing 0 of the next unmarked unary run.
    always_comb begin
        cand   = ~data_i & ~cov_i;
        first0 = cand & (~cand + {{(N-1){1'b0}}, 1'b1});
    end

    // Spread remainder flags over the K bits after the closing 0; bits past N-1 drop off.
    always_comb begin
        rem_new = '0;
        for (int t = 1; t <= K; t++) begin
            rem_new = rem_new | (first0 << t);
        end
        dlm_new = first0 << K;
    end

    // Merge the new flags and advance the covered region.
    always_comb begin
        rem_o = rem_i | rem_new;
        dlm_o = dlm_i | dlm_new;
        if (cand == '0) begin
            cov_o = '1;
        end else begin
            cov_o = cov_i | (first0 - {{(N-1){1'b0}}, 1'b1}) | first0 | rem_new;
        end
    end

endmodule

// File: rtl/rice_mark_lane.sv
// One speculative lane. It seeds the flag masks with the lane's carry-in
// assumption (J remainder bits carried in; J = 0 means a unary run
// continues) and runs a chain of marking cells long enough for the most
// code words that can start in the chunk.
module rice_mark_lane #(
    parameter int N = 16,
    parameter int K = 2,
    parameter int J = 0
) (
    input  logic [N-1:0] data_i,
    output logic [N-1:0] rem_o,
    output logic [N-1:0] dlm_o
);

    localparam int CELLS = int'(rice_mark_pkg::cells_for(N, K));

    logic [N-1:0] cov_c [CELLS+1];
    logic [N-1:0] rem_c [CELLS+1];
    logic [N-1:0] dlm_c [CELLS+1];

    // Seed masks from the carry-in assumption of this lane.
    always_comb begin
        for (int b = 0; b < N; b++) begin
            cov_c[0][b] = (b < J);
            rem_c[0][b] = (b < J);
            dlm_c[0][b] = (J > 0) && (b == J - 1);
        end
    end

    genvar c;
    generate
        for (c = 0; c < CELLS; c++) begin : g_cell
            rice_mark_cell #(.N(N), .K(K)) u_cell (
                .data_i (data_i),
                .cov_i  (cov_c[c]),
                .rem_i  (rem_c[c]),
                .dlm_i  (dlm_c[c]),
                .cov_o  (cov_c[c+1]),
                .rem_o  (rem_c[c+1]),
                .dlm_o  (dlm_c[c+1])
            );
        end
    endgenerate

    // The final covered mask is not needed outside the chain.
    assign rem_o = rem_c[CELLS];
    assign dlm_o = dlm_c[CELLS];

endmodule

// File: rtl/rice_mark_pipe.sv
// Output delay line: LAT register stages with a valid bit. LAT = 0 makes
// it a straight wire. The payload is cleared by reset along with valid.
module rice_mark_pipe #(
    parameter int W   = 8,
    parameter int LAT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic [W-1:0] d_i,
    output logic         v_o,
    output logic [W-1:0] d_o
);

    generate
        if (LAT == 0) begin : g_wire
            assign v_o = v_i;
            assign d_o = d_i;
        end else begin : g_regs
            logic [LAT-1:0] vs;
            logic [W-1:0]   st [LAT];

            // Shift valid and payload one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vs <= '0;
                    for (int s = 0; s < LAT; s++) st[s] <= '0;
                end else begin
                    vs[0] <= v_i;
                    st[0] <= d_i;
                    for (int s = 1; s < LAT; s++) begin
                        vs[s] <= vs[s-1];
                        st[s] <= st[s-1];
                    end
                end
            end

            assign v_o = vs[LAT-1];
            assign d_o = st[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/rice_spec_marker.sv
// Top level: evaluates all K+1 carry-in assumptions for one chunk in
// parallel and delivers chunk data plus per-lane remainder and delimiter
// masks after LAT register stages. Lane j sits at bits [j*N +: N].
// Assumes 0 <= K < N. Choosing the correct lane is left to the consumer.
module rice_spec_marker #(
    parameter int N   = 16,
    parameter int K   = 2,
    parameter int LAT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [N-1:0]         in_data,
    output logic                 out_valid,
    output logic [N-1:0]         out_data,
    output logic [(K+1)*N-1:0]   out_rem,
    output logic [(K+1)*N-1:0]   out_delim
);

    localparam int LANES = K + 1;
    localparam int PW    = N + 2 * LANES * N;

    logic [LANES*N-1:0] rem_all;
    logic [LANES*N-1:0] dlm_all;
    logic [PW-1:0]      pipe_out;

    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_lane
            rice_mark_lane #(.N(N), .K(K), .J(j)) u_lane (
                .data_i (in_data),
                .rem_o  (rem_all[j*N +: N]),
                .dlm_o  (dlm_all[j*N +: N])
            );
        end
    endgenerate

    rice_mark_pipe #(.W(PW), .LAT(LAT)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (in_valid),
        .d_i   ({dlm_all, rem_all, in_data}),
        .v_o   (out_valid),
        .d_o   (pipe_out)
    );

    // Split the delayed payload back into ports.
    assign out_data  = pipe_out[N-1:0];
    assign out_rem   = pipe_out[N +: LANES*N];
    assign out_delim = pipe_out[N + LANES*N +: LANES*N];

endmodule

// File: rtl/rice_spec_marker_chk.sv
// Property checker bound to every rice_spec_marker instance. It keeps its
// own delayed copy of the inputs to relate outputs to inputs over time.
module rice_spec_marker_chk #(
    parameter int N   = 16,
    parameter int K   = 2,
    parameter int LAT = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [N-1:0]         in_data,
    input  logic                 out_valid,
    input  logic [N-1:0]         out_data,
    input  logic [(K+1)*N-1:0]   out_rem,
    input  logic [(K+1)*N-1:0]   out_delim
);

    generate
        if (LAT > 0) begin : g_lat
            logic [LAT-1:0] vd;
            logic [N-1:0]   dd [LAT];

            // Reference delay of the input handshake and data.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vd <= '0;
                    for (int s = 0; s < LAT; s++) dd[s] <= '0;
                end else begin
                    vd[0] <= in_valid;
                    dd[0] <= in_data;
                    for (int s = 1; s < LAT; s++) begin
                        vd[s] <= vd[s-1];
                        dd[s] <= dd[s-1];
                    end
                end
            end

            // R8
            vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == vd[LAT-1]);

            // R8
            data_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> out_data == dd[LAT-1]);
        end
    endgenerate

    // R2
    lane0_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_data[0]) |-> (!out_rem[0] && !out_delim[0]));

    genvar j, i;
    generate
        if (K > 0) begin : g_rk
            // R7
            delim_in_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> ((out_delim & ~out_rem) == '0));

            for (j = 1; j <= K; j++) begin : g_carry
                // R3
                carry_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    out_valid |-> ((&out_rem[j*N +: j]) && out_delim[j*N + j - 1]));
            end

            for (i = K; i < N; i++) begin : g_term
                // R4
                delim_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (out_valid && out_delim[i]) |-> !out_data[i-K]);
            end
        end else begin : g_k0
            // R10
            k0_zero_delim_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (out_delim == ~out_data && out_rem == '0));
        end
    endgenerate

endmodule

bind rice_spec_marker rice_spec_marker_chk #(.N(N), .K(K), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_rem   (out_rem),
    .out_delim (out_delim)
);

// File: tb/rice_spec_marker_tb.sv
// Scoreboard bench: the driver pushes expected results from a bit-serial
// model; a monitor pops and compares on each valid output. A second
// instance covers K = 0 with two register stages.
module rice_spec_marker_tb;

    localparam int N  = 16;
    localparam int KA = 2;
    localparam int LA = 1;
    localparam int KB = 0;
    localparam int LB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [N-1:0] in_data = '0;

    logic                va, vb;
    logic [N-1:0]        da, db;
    logic [(KA+1)*N-1:0] ra, dla;
    logic [(KB+1)*N-1:0] rb, dlb;

    int total = 0;
    int bad = 0;

    logic [N-1:0]        qa_d [$];
    logic [(KA+1)*N-1:0] qa_r [$];
    logic [(KA+1)*N-1:0] qa_m [$];
    logic [N-1:0]        qb_d [$];
    logic [(KB+1)*N-1:0] qb_r [$];
    logic [(KB+1)*N-1:0] qb_m [$];

    logic [(KA+1)*N-1:0] last_ra, last_dla;

    always #4 clk = ~clk;

    rice_spec_marker #(.N(N), .K(KA), .LAT(LA)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(va), .out_data(da), .out_rem(ra), .out_delim(dla)
    );

    rice_spec_marker #(.N(N), .K(KB), .LAT(LB)) u_dut_k0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(vb), .out_data(db), .out_rem(rb), .out_delim(dlb)
    );

    // Bit-serial reference: returns {delim, rem} for one lane.
    function automatic logic [2*N-1:0] ref_lane(input logic [N-1:0] d, input int k, input int lane);
        logic [N-1:0] r = '0;
        logic [N-1:0] m = '0;
        int left = lane;
        for (int i = 0; i < N; i++) begin
            if (left > 0) begin
                r[i] = 1'b1;
                left--;
                if (left == 0) m[i] = 1'b1;
            end else if (!d[i]) begin
                if (k == 0) m[i] = 1'b1;
                else left = k;
            end
        end
        return {m, r};
    endfunction

    task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one chunk and queue its expected marks.
    task automatic send(input logic [N-1:0] d);
        logic [(KA+1)*N-1:0] er, em;
        logic [(KB+1)*N-1:0] fr, fm;
        logic [2*N-1:0] res;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        for (int l = 0; l <= KA; l++) begin
            res = ref_lane(d, KA, l);
            er[l*N +: N] = res[N-1:0];
            em[l*N +: N] = res[2*N-1:N];
        end
        for (int l = 0; l <= KB; l++) begin
            res = ref_lane(d, KB, l);
            fr[l*N +: N] = res[N-1:0];
            fm[l*N +: N] = res[2*N-1:N];
        end
        qa_d.push_back(d); qa_r.push_back(er); qa_m.push_back(em);
        qb_d.push_back(d); qb_r.push_back(fr); qb_m.push_back(fm);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compare each valid output against the scoreboard (R1 lane slicing).
    always @(negedge clk) begin
        if (rst_n && va) begin
            if (qa_d.size() == 0) begin
                check(1'b0, "R11 unexpected valid", da, '0);
            end else begin
                logic [N-1:0] ed;
                logic [(KA+1)*N-1:0] er, em;
                ed = qa_d.pop_front(); er = qa_r.pop_front(); em = qa_m.pop_front();
                check(da == ed, "R8 data", da, ed);
                for (int l = 0; l <= KA; l++) begin
                    check(ra[l*N +: N] == er[l*N +: N], l == 0 ? "R2/R4 lane0 rem" : "R3/R4 lane rem",
                          ra[l*N +: N], er[l*N +: N]);
                    check(dla[l*N +: N] == em[l*N +: N], l == 0 ? "R2/R4 lane0 delim" : "R3/R4 lane delim",
                          dla[l*N +: N], em[l*N +: N]);
                    check((dla[l*N +: N] & ~ra[l*N +: N]) == '0, "R7 delim subset",
                          dla[l*N +: N], dla[l*N +: N] & ra[l*N +: N]);
                end
                last_ra  = ra;
                last_dla = dla;
            end
        end
        if (rst_n && vb) begin
            if (qb_d.size() == 0) begin
                check(1'b0, "R11 unexpected valid k0", db, '0);
            end else begin
                logic [N-1:0] ed;
                logic [(KB+1)*N-1:0] er, em;
                ed = qb_d.pop_front(); er = qb_r.pop_front(); em = qb_m.pop_front();
                check(db == ed, "R8 data k0", db, ed);
                check(rb == er, "R10 rem", rb, er);
                check(dlb == em && dlb == ~db, "R10 delim", dlb, em);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9: quiet outputs during and right after reset.
        repeat (3) @(negedge clk);
        check(!va && !vb, "R9 valid in reset", {15'b0, va}, '0);
        check(ra == '0 && dla == '0, "R9 flags in reset", ra[N-1:0], '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!va && !vb, "R9 valid after reset", {15'b0, vb}, '0);

        // R8: latency of each instance.
        send(16'h1234);
        @(negedge clk);
        in_valid = 1'b0;
        check(va == 1'b1 && vb == 1'b0, "R8 latency one", {14'b0, va, vb}, 16'h2);
        @(negedge clk);
        check(va == 1'b0 && vb == 1'b1, "R8 latency two", {14'b0, va, vb}, 16'h1);
        repeat (3) idle();

        // R4 and R3: all-zero chunk, hand-computed masks (R1 slices).
        send(16'h0000); idle(); idle();
        check(last_ra[0 +: N] == 16'h6DB6, "R4 lane0 rem zeros", last_ra[0 +: N], 16'h6DB6);
        check(last_dla[0 +: N] == 16'h4924, "R4 lane0 delim zeros", last_dla[0 +: N], 16'h4924);
        check(last_ra[2*N +: N] == 16'hB6DB, "R3 lane2 rem zeros", last_ra[2*N +: N], 16'hB6DB);
        check(last_dla[2*N +: N] == 16'h2492, "R3 lane2 delim zeros", last_dla[2*N +: N], 16'h2492);

        // R5: unary closes at bit 14, remainder cut off at bit 15.
        send(16'hBFFF); idle(); idle();
        check(last_ra[0 +: N] == 16'h8000, "R5 truncated rem", last_ra[0 +: N], 16'h8000);
        check(last_dla[0 +: N] == 16'h0000, "R5 no delim", last_dla[0 +: N], 16'h0000);

        // R6: unary run fills the chunk.
        send(16'hFFFF); idle(); idle();
        check(last_ra[0 +: N] == 16'h0000, "R6 open unary rem", last_ra[0 +: N], 16'h0000);
        check(last_dla[0 +: N] == 16'h0000, "R6 open unary delim", last_dla[0 +: N], 16'h0000);
        check(last_dla[N +: N] == 16'h0001, "R6 lane1 delim", last_dla[N +: N], 16'h0001);

        // R11: back-to-back corner chunks, then random traffic with gaps.
        send(16'h0001); send(16'h8000); send(16'h7FFF); send(16'hAAAA); send(16'h5555);
        for (int n = 0; n < 400; n++) begin
            logic [N-1:0] d;
            d = (n % 3 == 0) ? N'($urandom | $urandom) : N'($urandom);
            if ($urandom % 4 != 0) send(d);
            else idle();
        end
        repeat (6) idle();
        check(qa_d.size() == 0 && qb_d.size() == 0, "R11 scoreboard drained",
              N'(qa_d.size()), '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule